// File: doc/BRIEF.md
# Host-to-Coprocessor Mailbox Bridge

This block connects an 8-bit host bus to an embedded coprocessor through a small mirrored register window. A byte can go in each direction through its own one-byte mailbox, and each mailbox has a ready flag. The coprocessor can load a countdown timer that keeps a busy flag set until the count runs out or the host cancels it. The host can also read a status byte, and it can hold the coprocessor in reset through a control bit.

The host side is a single-cycle strobe port. On a read, the data is combinational and is valid while the read strobe is high. The side effects of a read or a write take effect on the clock edge that ends the strobe. The same offset can do different things on a read and on a write. The coprocessor side sees the inbound mailbox byte and its ready flag, and can consume it. It can also fill the outbound mailbox and load the timer. It receives a hold level and a run flag, and the run flag rises a fixed number of clocks after the hold is released.

Top module: `mbox_bridge`

## Requirements
- R1: Decode uses host_addr AND 0xFF06. A masked value of 0x3800 selects the outbound data register, 0x3802 selects the mailbox/timer register and 0x3804 selects the control/status register. As a result, address bit 0 is ignored and the window repeats every 8 bytes across 0x3800–0x38FF.
- R2: A host read at 0x3800 returns the coprocessor-to-host byte when its ready flag is set, and the flag clears on that edge. When the flag is clear, the read returns 0x00.
- R3: A host write at 0x3802 stores host_wdata in the host-to-coprocessor mailbox and sets cop_rx_ready from the next edge on. If the write and cop_rx_take fall in the same cycle, the write wins. A cop_rx_take on its own clears the flag.
- R4: A host read at 0x3802 returns 0x00 and clears both the timer count and the busy flag.
- R5: A host read at 0x3804 returns the status byte without side effects. Bit 0 is coprocessor-to-host ready, bit 3 is host-to-coprocessor ready, bit 7 is busy, and every other bit is 0.
- R6: A timer_load with a nonzero timer_value loads the count and sets busy. The count then drops by one per clock, and busy clears on the edge where the count reaches 0. After a load of N, busy stays set for N edges.
- R7: On a host write at 0x3804, bit 0 of the data drives cop_hold. A 0-to-1 change clears both ready flags, the busy flag, the timer and cop_run. A write of 1 while the hold is already 1 clears nothing.
- R8: cop_run is 0 while cop_hold is 1. It rises WAIT_CYCLES clocks after hold is low, either after rst_n or after a release. While cop_run is 0, cop_tx_load, cop_rx_take and timer_load are ignored.
- R9: cop_tx_load writes cop_tx_data into the coprocessor-to-host mailbox and sets its ready flag. If the load falls in the same cycle as a host read at 0x3800, the read returns the old byte and the load wins, leaving the flag set.
- R10: Reads at masked offset 0x3806 or outside page 0x38 return 0x00, and writes there have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 16 | Host address |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, 0 when host_rd is low |
| cop_rx_data | output | 8 | Host-to-coprocessor mailbox byte |
| cop_rx_ready | output | 1 | Host-to-coprocessor mailbox full |
| cop_rx_take | input | 1 | Coprocessor consumes inbound byte |
| cop_tx_data | input | 8 | Coprocessor outbound byte |
| cop_tx_load | input | 1 | Coprocessor writes outbound byte |
| timer_load | input | 1 | Load the busy timer |
| timer_value | input | 16 | Timer load value |
| cop_hold | output | 1 | Coprocessor held in reset |
| cop_run | output | 1 | Coprocessor ready after reset delay |

## Verification
A wrong ready flag or busy flag appears at the ports no later than the next zero-cost status peek at 0x3804. A wrong mailbox byte appears on the next data read or on cop_rx_data. A timer that is off by one moves the busy drop by exactly one edge, so the bench checks the status byte on both sides of the expected edge. A wrong reset sequence shows in two ways: cop_run rises too early or too late, or state that a repeated write of 1 should have kept is lost. For this reason the bench sets state while the hold is active and reads it back afterwards.

// File: rtl/mbox_pkg.sv
// Shared constants and types for the mailbox bridge.
// Assumes a 16-bit host address and byte-wide host data.
package mbox_pkg;
    localparam logic [15:0] ADDR_MASK = 16'hFF06;
    localparam logic [15:0] OFF_OUTB  = 16'h3800;
    localparam logic [15:0] OFF_MBOX  = 16'h3802;
    localparam logic [15:0] OFF_CTRL  = 16'h3804;

    localparam int STAT_OUTB_RDY = 0;
    localparam int STAT_INB_RDY  = 3;
    localparam int STAT_BUSY     = 7;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_OUTB = 2'd1,
        SEL_MBOX = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/mbox_decode.sv
// Address decoder: masks the host address and selects one register.
// Assumes the mask folds bit 0 and mirrors the 8-byte window.
module mbox_decode
    import mbox_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    output reg_sel_e      sel
);
    logic [15:0] masked;

    // Fold the address and pick the register it names.
    always_comb begin
        masked = addr[15:0] & ADDR_MASK;
        unique case (masked)
            OFF_OUTB: sel = SEL_OUTB;
            OFF_MBOX: sel = SEL_MBOX;
            OFF_CTRL: sel = SEL_CTRL;
            default:  sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/mbox_slot.sv
// One-byte mailbox with a ready flag.
// Priority: clear > put > take. Data is kept on clear.
module mbox_slot #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          put,
    input  logic [DW-1:0] put_data,
    input  logic          take,
    output logic [DW-1:0] data,
    output logic          ready
);
    // Hold the byte and track whether it is unread.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data  <= '0;
            ready <= 1'b0;
        end else if (clr) begin
            ready <= 1'b0;
        end else if (put) begin
            data  <= put_data;
            ready <= 1'b1;
        end else if (take) begin
            ready <= 1'b0;
        end
    end
endmodule

// File: rtl/mbox_timer.sv
// Busy countdown: a nonzero load sets busy, each clock decrements,
// busy drops when the count reaches zero. Clear has priority.
module mbox_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          busy,
    output logic [TW-1:0] count
);
    localparam logic [TW-1:0] ONE = TW'(1);

    // Count down and drop busy on the final step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
            busy  <= 1'b0;
        end else if (load && load_val != '0) begin
            count <= load_val;
            busy  <= 1'b1;
        end else if (count != '0) begin
            count <= count - ONE;
            if (count == ONE) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/mbox_reset_seq.sv
// Coprocessor reset sequencer: hold level from the control bit, a
// one-cycle pulse on its rising write, and a run flag after WAIT clocks.
module mbox_reset_seq #(
    parameter int WAIT_CYCLES = 65536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_we,
    input  logic ctrl_bit,
    output logic hold,
    output logic run,
    output logic rst_pulse
);
    localparam int CW = $clog2(WAIT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Edge detect on the control bit against the held level.
    always_comb rst_pulse = ctrl_we && ctrl_bit && !hold;

    // Track the hold level written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)       hold <= 1'b0;
        else if (ctrl_we) hold <= ctrl_bit;
    end

    // Count the post-release delay and raise run at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_pulse || hold) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (!run) begin
            if (cnt == LAST) run <= 1'b1;
            else             cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mbox_bridge.sv
// Host-to-coprocessor mailbox bridge top. Host strobes are single-cycle
// and read data is combinational; coprocessor inputs are gated by run.
module mbox_bridge
    import mbox_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 8,
    parameter int TW          = 16,
    parameter int WAIT_CYCLES = 65536
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] host_addr,
    input  logic          host_rd,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic [DW-1:0] cop_rx_data,
    output logic          cop_rx_ready,
    input  logic          cop_rx_take,
    input  logic [DW-1:0] cop_tx_data,
    input  logic          cop_tx_load,
    input  logic          timer_load,
    input  logic [TW-1:0] timer_value,
    output logic          cop_hold,
    output logic          cop_run
);
    reg_sel_e      host_sel;
    logic [DW-1:0] outb_data;
    logic          outb_ready;
    logic          busy;
    logic [TW-1:0] tmr_count;
    logic          rst_pulse;
    logic          rd_outb, rd_mbox, wr_mbox, wr_ctrl;
    logic          tx_put, rx_take, tmr_load, tmr_clr;
    logic [DW-1:0] status;

    mbox_decode #(.AW(AW)) u_dec (.addr(host_addr), .sel(host_sel));

    // Qualify strobes with the decoded register and gate coprocessor inputs.
    always_comb begin
        rd_outb  = host_rd && host_sel == SEL_OUTB;
        rd_mbox  = host_rd && host_sel == SEL_MBOX;
        wr_mbox  = host_wr && host_sel == SEL_MBOX;
        wr_ctrl  = host_wr && host_sel == SEL_CTRL;
        tx_put   = cop_tx_load && cop_run;
        rx_take  = cop_rx_take && cop_run;
        tmr_load = timer_load && cop_run;
        tmr_clr  = rst_pulse || rd_mbox;
    end

    mbox_reset_seq #(.WAIT_CYCLES(WAIT_CYCLES)) u_rst (
        .clk(clk), .rst_n(rst_n), .ctrl_we(wr_ctrl), .ctrl_bit(host_wdata[0]),
        .hold(cop_hold), .run(cop_run), .rst_pulse(rst_pulse)
    );

    mbox_slot #(.DW(DW)) u_outb (
        .clk(clk), .rst_n(rst_n), .clr(rst_pulse), .put(tx_put),
        .put_data(cop_tx_data), .take(rd_outb),
        .data(outb_data), .ready(outb_ready)
    );

    mbox_slot #(.DW(DW)) u_inb (
        .clk(clk), .rst_n(rst_n), .clr(rst_pulse), .put(wr_mbox),
        .put_data(host_wdata), .take(rx_take),
        .data(cop_rx_data), .ready(cop_rx_ready)
    );

    mbox_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .load(tmr_load),
        .load_val(timer_value), .busy(busy), .count(tmr_count)
    );

    // Assemble the status byte and mux the host read data.
    always_comb begin
        status                = '0;
        status[STAT_OUTB_RDY] = outb_ready;
        status[STAT_INB_RDY]  = cop_rx_ready;
        status[STAT_BUSY]     = busy;
        host_rdata            = '0;
        if (host_rd) begin
            case (host_sel)
                SEL_OUTB: host_rdata = outb_ready ? outb_data : '0;
                SEL_CTRL: host_rdata = status;
                default:  host_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/mbox_bridge_chk.sv
// Property checker for the mailbox bridge, attached by bind below.
module mbox_bridge_chk
    import mbox_pkg::*;
#(
    parameter int DW = 8,
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_rd,
    input logic          host_wr,
    input logic [DW-1:0] host_wdata,
    input logic [DW-1:0] host_rdata,
    input reg_sel_e      host_sel,
    input logic          outb_ready,
    input logic          cop_rx_ready,
    input logic [DW-1:0] cop_rx_data,
    input logic          busy,
    input logic [TW-1:0] tmr_count,
    input logic          tmr_clr,
    input logic          tmr_load,
    input logic          rst_pulse,
    input logic          cop_hold,
    input logic          cop_run
);
    // R2: empty outbound read gives zero
    a_r2_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_sel == SEL_OUTB && !outb_ready) |-> host_rdata == '0);

    // R3: host mailbox write lands on the coprocessor side
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == SEL_MBOX) |=>
        (cop_rx_ready && cop_rx_data == $past(host_wdata)));

    // R4: mailbox-offset read cancels the timer
    a_r4_read_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_sel == SEL_MBOX) |=> (tmr_count == '0 && !busy));

    // R6: free-running count steps down by one
    a_r6_timer_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_count != '0 && !tmr_clr && !tmr_load) |=>
        tmr_count == $past(tmr_count) - TW'(1));

    // R6: busy never set with a zero count
    a_r6_busy_count: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> tmr_count != '0);

    // R7: reset pulse clears flags and run
    a_r7_pulse_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |=> (!cop_run && !cop_rx_ready && !outb_ready && !busy));

    // R8: no run while held
    a_r8_hold_no_run: assert property (@(posedge clk) disable iff (!rst_n)
        cop_hold |-> !cop_run);
endmodule

bind mbox_bridge mbox_bridge_chk #(.DW(DW), .TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_sel(host_sel),
    .outb_ready(outb_ready), .cop_rx_ready(cop_rx_ready),
    .cop_rx_data(cop_rx_data), .busy(busy), .tmr_count(tmr_count),
    .tmr_clr(tmr_clr), .tmr_load(tmr_load), .rst_pulse(rst_pulse),
    .cop_hold(cop_hold), .cop_run(cop_run)
);

// File: tb/mbox_bridge_test.sv
// Self-checking bench: a host vector table, then directed tests.
module mbox_bridge_test;
    localparam int CLK_PERIOD = 10;
    localparam int WAITC      = 65536;
    localparam int NVEC       = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] host_addr = '0;
    logic        host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [7:0]  cop_rx_data;
    logic        cop_rx_ready;
    logic        cop_rx_take = 1'b0;
    logic [7:0]  cop_tx_data = '0;
    logic        cop_tx_load = 1'b0;
    logic        timer_load = 1'b0;
    logic [15:0] timer_value = '0;
    logic        cop_hold, cop_run;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] rv;

    // {is_write, address, data or expected read}
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b0, 16'h3804, 8'h00},
        {1'b1, 16'h3802, 8'hA5},
        {1'b0, 16'h3804, 8'h08},
        {1'b0, 16'h3805, 8'h08},
        {1'b0, 16'h38FC, 8'h08},
        {1'b0, 16'h3800, 8'h00},
        {1'b0, 16'h3802, 8'h00},
        {1'b1, 16'h3806, 8'hFF},
        {1'b0, 16'h3806, 8'h00},
        {1'b0, 16'h3904, 8'h00},
        {1'b1, 16'h380B, 8'h3C}
    };

    mbox_bridge uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cop_rx_data(cop_rx_data), .cop_rx_ready(cop_rx_ready),
        .cop_rx_take(cop_rx_take), .cop_tx_data(cop_tx_data),
        .cop_tx_load(cop_tx_load), .timer_load(timer_load),
        .timer_value(timer_value), .cop_hold(cop_hold), .cop_run(cop_run)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(posedge clk);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    // Status read with no clock edge in between (no side effects).
    task automatic peek_status(output logic [7:0] d);
        host_addr = 16'h3804; host_rd = 1'b1;
        #1 d = host_rdata;
        host_rd = 1'b0;
        #1;
    endtask

    task automatic cop_pulse(input logic tx, input logic tk, input logic tl,
                             input logic [7:0] d, input logic [15:0] tv);
        @(negedge clk);
        cop_tx_load = tx; cop_rx_take = tk; timer_load = tl;
        cop_tx_data = d; timer_value = tv;
        @(posedge clk);
        @(negedge clk);
        cop_tx_load = 1'b0; cop_rx_take = 1'b0; timer_load = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // Reset state
        peek_status(rv);
        check("R5 reset status", {8'h0, rv}, 16'h0000);
        check("R8 reset hold", {15'h0, cop_hold}, 16'h0);
        check("R8 reset run", {15'h0, cop_run}, 16'h0);
        check("R3 reset rx_ready", {15'h0, cop_rx_ready}, 16'h0);

        // R8: coprocessor load ignored before run
        cop_pulse(1'b1, 1'b0, 1'b1, 8'h77, 16'd9);
        peek_status(rv);
        check("R8 load ignored before run", {8'h0, rv}, 16'h0000);
        repeat (10) @(negedge clk);
        check("R8 run not early", {15'h0, cop_run}, 16'h0);
        repeat (WAITC) @(negedge clk);
        check("R8 run after delay", {15'h0, cop_run}, 16'h1);

        // Host vector table (R1 R2 R4 R5 R10)
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][24]) host_write(VEC[i][23:8], VEC[i][7:0]);
            else begin
                host_read(VEC[i][23:8], rv);
                check($sformatf("R1/R5/R10 vector %0d", i), {8'h0, rv}, {8'h0, VEC[i][7:0]});
            end
        end
        // R3: mirrored write replaced the byte
        check("R3 rx data", {8'h0, cop_rx_data}, 16'h003C);
        check("R3 rx ready", {15'h0, cop_rx_ready}, 16'h1);
        cop_pulse(1'b0, 1'b1, 1'b0, 8'h00, 16'd0);
        check("R3 take clears", {15'h0, cop_rx_ready}, 16'h0);

        // R2 / R9: outbound mailbox
        cop_pulse(1'b1, 1'b0, 1'b0, 8'h5A, 16'd0);
        peek_status(rv);
        check("R9 outbound ready", {8'h0, rv}, 16'h0001);
        host_read(16'h3801, rv);
        check("R2 read data", {8'h0, rv}, 16'h005A);
        host_read(16'h3800, rv);
        check("R2 second read empty", {8'h0, rv}, 16'h0000);

        // R9: load wins over same-cycle host read
        cop_pulse(1'b1, 1'b0, 1'b0, 8'h11, 16'd0);
        @(negedge clk);
        host_addr = 16'h3800; host_rd = 1'b1;
        cop_tx_load = 1'b1; cop_tx_data = 8'h22;
        #1 rv = host_rdata;
        check("R9 collision returns old", {8'h0, rv}, 16'h0011);
        @(posedge clk);
        @(negedge clk);
        host_rd = 1'b0; cop_tx_load = 1'b0;
        peek_status(rv);
        check("R9 collision ready kept", {8'h0, rv}, 16'h0001);
        host_read(16'h3800, rv);
        check("R9 collision new byte", {8'h0, rv}, 16'h0022);

        // R6: timer of 4 holds busy for exactly 4 edges
        cop_pulse(1'b0, 1'b0, 1'b1, 8'h00, 16'd4);
        peek_status(rv);
        check("R6 busy after load", {8'h0, rv}, 16'h0080);
        repeat (3) @(negedge clk);
        peek_status(rv);
        check("R6 busy at count 1", {8'h0, rv}, 16'h0080);
        @(negedge clk);
        peek_status(rv);
        check("R6 busy drops at 0", {8'h0, rv}, 16'h0000);

        // R4: host read cancels timer
        cop_pulse(1'b0, 1'b0, 1'b1, 8'h00, 16'd100);
        host_read(16'h3803, rv);
        check("R4 read returns zero", {8'h0, rv}, 16'h0000);
        peek_status(rv);
        check("R4 busy cancelled", {8'h0, rv}, 16'h0000);

        // R7: rising control write clears state
        host_write(16'h3802, 8'h99);
        cop_pulse(1'b1, 1'b0, 1'b1, 8'h44, 16'd500);
        peek_status(rv);
        check("R7 setup status", {8'h0, rv}, 16'h0089);
        host_write(16'h3804, 8'hFF);
        peek_status(rv);
        check("R7 reset clears status", {8'h0, rv}, 16'h0000);
        check("R7 hold set", {15'h0, cop_hold}, 16'h1);
        check("R8 run low in hold", {15'h0, cop_run}, 16'h0);
        cop_pulse(1'b1, 1'b0, 1'b0, 8'h55, 16'd0);
        peek_status(rv);
        check("R8 load ignored in hold", {8'h0, rv}, 16'h0000);
        host_write(16'h3802, 8'h66);
        host_write(16'h3805, 8'h01);
        peek_status(rv);
        check("R7 repeated 1 no reset", {8'h0, rv}, 16'h0008);
        host_write(16'h3804, 8'h00);
        check("R7 hold released", {15'h0, cop_hold}, 16'h0);
        repeat (WAITC + 2) @(negedge clk);
        check("R8 run after release", {15'h0, cop_run}, 16'h1);
        check("R3 byte kept over hold", {8'h0, cop_rx_data}, 16'h0066);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule